// File: doc/BRIEF.md
# Message Signalled Interrupt Collector

This block sits beside the inbound side of a bus and watches each inbound memory write. A write is a message only when its 64-bit address equals the doorbell address that software has programmed. The low bits of its data then name a vector. If that vector is enabled, its status bit is latched. A mask register decides which of the latched vectors may drive the interrupt line toward the CPU. A global switch in a control word must also be on before the line can rise.

Software programs the block through a small register port with byte offsets. The offsets stay fixed because drivers decode them. After reset, software zeroes enable and mask and clears status. It then sets the doorbell address and the global switch. The interrupt handler reads the status register and writes back the bits it saw. Writing a one clears a bit, and writing all ones clears everything.

Top module: `msi_collector`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The register offsets are as follows. 0x050 is the control word, and only bit 16 (the global enable) is held; all other bits read zero. 0x820 is the lower doorbell word and 0x824 the upper doorbell word. 0x828 is enable, 0x82C is mask and 0x830 is status. Bit i of enable, mask and status belongs to vector i. Any other offset reads zero.
- R3: A message sets status bit v on the next clock edge when it meets three conditions. `msg_valid` is high, `msg_addr` equals {upper word, lower word}, and `msg_data` equals v with v < NVEC and enable bit v set.
- R4: A write whose address differs from the doorbell in any bit leaves status unchanged.
- R5: A message to a vector whose enable bit is clear leaves status unchanged.
- R6: A message whose data value is NVEC or above leaves status unchanged.
- R7: A register write of a value to offset 0x830 clears every status bit where that value has a one and leaves the other bits alone. Writing all ones clears every pending vector.
- R8: A message and a software clear that hit the same bit in the same cycle leave that bit set.
- R9: `irq_o` is high exactly when the global enable is set and at least one status bit has its mask bit clear. Mask does not stop a vector from being latched.
- R10: While the global enable bit is clear, `irq_o` stays low whatever status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | RAW | Register byte offset, for both read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| msg_valid | input | 1 | Inbound memory write is present |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data (vector number) |
| irq_o | output | 1 | Interrupt request toward the CPU |

## Verification
The bench builds the block with its defaults: NVEC = 32 and a 12-bit register offset. This puts vector 31, the highest status bit, within reach, along with the data values 32 and 37, which lie just past the last vector. The doorbell is placed above 4 GiB, so a mismatch in the upper word alone must be rejected. A message and a full clear can meet in one cycle. A mixed stretch of random traffic then hits matching and non-matching addresses while the mask and the global switch change.

// File: rtl/msi_collector.sv
module msi_collector #(
  parameter int NVEC = 32,
  parameter int RAW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [RAW-1:0]  cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            msg_valid,
  input  logic [63:0]     msg_addr,
  input  logic [31:0]     msg_data,
  output logic            irq_o
);
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam logic [RAW-1:0] A_CTL  = RAW'(12'h050);
  localparam logic [RAW-1:0] A_DBLO = RAW'(12'h820);
  localparam logic [RAW-1:0] A_DBHI = RAW'(12'h824);
  localparam logic [RAW-1:0] A_EN   = RAW'(12'h828);
  localparam logic [RAW-1:0] A_MSK  = RAW'(12'h82C);
  localparam logic [RAW-1:0] A_STAT = RAW'(12'h830);
  localparam int GEN_BIT = 16;

  logic [31:0]     db_lo, db_hi;
  logic [NVEC-1:0] en_q, mask_q, stat_q;
  logic            gen_q;

  logic [VW-1:0]   vec;
  logic            hit;
  logic [NVEC-1:0] set_v, clr_v;

  assign vec   = msg_data[VW-1:0];
  assign hit   = msg_valid && (msg_addr == {db_hi, db_lo}) &&
                 (msg_data < 32'(NVEC)) && en_q[vec];
  assign set_v = hit ? (NVEC'(1) << vec) : '0;
  assign clr_v = (cfg_we && cfg_addr == A_STAT) ? cfg_wdata[NVEC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_lo  <= '0;
      db_hi  <= '0;
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
      gen_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          A_CTL:   gen_q  <= cfg_wdata[GEN_BIT];
          A_DBLO:  db_lo  <= cfg_wdata;
          A_DBHI:  db_hi  <= cfg_wdata;
          A_EN:    en_q   <= cfg_wdata[NVEC-1:0];
          A_MSK:   mask_q <= cfg_wdata[NVEC-1:0];
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~clr_v) | set_v;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTL:   cfg_rdata[GEN_BIT] = gen_q;
      A_DBLO:  cfg_rdata = db_lo;
      A_DBHI:  cfg_rdata = db_hi;
      A_EN:    cfg_rdata = 32'(en_q);
      A_MSK:   cfg_rdata = 32'(mask_q);
      A_STAT:  cfg_rdata = 32'(stat_q);
      default: cfg_rdata = '0;
    endcase
  end

  assign irq_o = gen_q & |(stat_q & ~mask_q);
endmodule

// File: rtl/msi_collector_chk.sv
module msi_collector_chk #(
  parameter int NVEC = 32,
  parameter int RAW  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [RAW-1:0]  cfg_addr,
  input logic [31:0]     cfg_wdata,
  input logic            msg_valid,
  input logic [63:0]     msg_addr,
  input logic [31:0]     msg_data,
  input logic            irq_o,
  input logic [31:0]     db_lo,
  input logic [31:0]     db_hi,
  input logic [NVEC-1:0] en_q,
  input logic [NVEC-1:0] stat_q,
  input logic            gen_q
);
  logic match;
  logic swclr;
  assign match = msg_valid && (msg_addr == {db_hi, db_lo});
  assign swclr = cfg_we && (cfg_addr == RAW'(12'h830));

  for (genvar i = 0; i < NVEC; i++) begin : g_bit
    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match && msg_data == 32'(i) && en_q[i] |=> stat_q[i]);
    // R8
    set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match && msg_data == 32'(i) && en_q[i] && swclr && cfg_wdata[i] |=> stat_q[i]);
    // R4 R5 R6
    spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[i]) |-> $past(match && msg_data == 32'(i) && en_q[i]));
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swclr && cfg_wdata[i] && !(match && msg_data == 32'(i)) |=> !stat_q[i]);
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !cfg_we |=> irq_o);
  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == RAW'(12'h050) && !cfg_wdata[16] |=> !irq_o);
  // R1
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_o && stat_q == '0 && !gen_q);
endmodule

bind msi_collector msi_collector_chk #(.NVEC(NVEC), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_addr(msg_addr),
  .msg_data(msg_data), .irq_o(irq_o), .db_lo(db_lo), .db_hi(db_hi),
  .en_q(en_q), .stat_q(stat_q), .gen_q(gen_q)
);

// File: tb/msi_collector_bench.sv
`timescale 1ns/1ps
module msi_collector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        irq_o;

  always #2 clk = ~clk;

  msi_collector u_msi_collector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .irq_o(irq_o)
  );

  int unsigned n_chk = 0, n_bad = 0;
  bit done = 0;
  string req = "R1";

  bit [31:0] m_lo, m_hi, m_en, m_mask, m_stat;
  bit        m_gen;

  localparam bit [63:0] DB = 64'h0000_0001_3000_0040;

  function automatic bit [31:0] m_read(bit [11:0] a);
    case (a)
      12'h050: return m_gen ? 32'h0001_0000 : 32'h0;
      12'h820: return m_lo;
      12'h824: return m_hi;
      12'h828: return m_en;
      12'h82C: return m_mask;
      12'h830: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cycle();
    bit [31:0] set, clr;
    bit exp_irq;
    @(posedge clk);
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_en = 0; m_mask = 0; m_stat = 0; m_gen = 0;
    end else begin
      set = 0;
      if (msg_valid && msg_addr == {m_hi, m_lo} && msg_data < 32 && m_en[msg_data[4:0]])
        set = 32'h1 << msg_data[4:0];
      clr = (cfg_we && cfg_addr == 12'h830) ? cfg_wdata : 32'h0;
      if (cfg_we) begin
        case (cfg_addr)
          12'h050: m_gen  = cfg_wdata[16];
          12'h820: m_lo   = cfg_wdata;
          12'h824: m_hi   = cfg_wdata;
          12'h828: m_en   = cfg_wdata;
          12'h82C: m_mask = cfg_wdata;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | set;
    end
    @(negedge clk);
    exp_irq = m_gen && ((m_stat & ~m_mask) != 0);
    n_chk++;
    if (irq_o !== exp_irq || cfg_rdata !== m_read(cfg_addr)) begin
      n_bad++;
      $display("FAIL %s: irq=%0b rdata[%h]=%h expected irq=%0b rdata=%h",
               req, irq_o, cfg_addr, cfg_rdata, exp_irq, m_read(cfg_addr));
    end
  endtask

  task automatic idle(bit [11:0] a);
    cfg_we = 0; msg_valid = 0; cfg_addr = a;
    cycle();
  endtask

  task automatic wr(bit [11:0] a, bit [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; msg_valid = 0;
    cycle();
    cfg_we = 0; cfg_addr = 12'h830;
  endtask

  task automatic msg(bit [63:0] a, bit [31:0] d);
    msg_valid = 1; msg_addr = a; msg_data = d; cfg_we = 0; cfg_addr = 12'h830;
    cycle();
    msg_valid = 0;
    idle(12'h830);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cycle();
    rst_n = 1;
    // R1: reset state of every register
    req = "R1";
    foreach (DB[i]) if (i < 7) idle((i == 0) ? 12'h050 : 12'h81C + 12'(4 * i));
    // R2: register offsets and readback
    req = "R2";
    wr(12'h820, DB[31:0]);   idle(12'h820);
    wr(12'h824, DB[63:32]);  idle(12'h824);
    wr(12'h828, 32'h8000_0005); idle(12'h828);
    wr(12'h050, 32'hFFFF_FFFF); idle(12'h050);
    idle(12'h900);
    // R3: matching messages, including the top vector
    req = "R3";
    msg(DB, 2);
    msg(DB, 31);
    // R7: clear one bit, then all
    req = "R7";
    wr(12'h830, 32'h0000_0004); idle(12'h830);
    wr(12'h830, 32'hFFFF_FFFF); idle(12'h830);
    // R4: upper-word and lower-word mismatch
    req = "R4";
    msg(DB ^ 64'h1_0000_0000, 0);
    msg(DB ^ 64'h4, 0);
    // R5: disabled vector
    req = "R5";
    msg(DB, 1);
    // R6: out-of-range data
    req = "R6";
    msg(DB, 32);
    msg(DB, 37);
    // R9: mask blocks the line, not the capture
    req = "R9";
    wr(12'h82C, 32'h8000_0004);
    msg(DB, 2);
    msg(DB, 31);
    msg(DB, 0);
    wr(12'h830, 32'h0000_0001);
    // R8: set and clear of the same bit together
    req = "R8";
    msg_valid = 1; msg_addr = DB; msg_data = 0;
    cfg_we = 1; cfg_addr = 12'h830; cfg_wdata = 32'hFFFF_FFFF;
    cycle();
    msg_valid = 0; cfg_we = 0;
    idle(12'h830);
    // R10: global enable gates the line
    req = "R10";
    wr(12'h050, 32'h0);
    idle(12'h830);
    wr(12'h050, 32'h0001_0000);
    // mixed traffic, R3 R4 R5 R6 R7 R9
    req = "R3-mixed";
    wr(12'h828, 32'hA5C3_0F71);
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 9);
      msg_valid = (r < 6);
      msg_addr  = (r == 5) ? (DB ^ (64'h1 << $urandom_range(0, 63))) : DB;
      msg_data  = (r == 4) ? $urandom_range(32, 300) : $urandom_range(0, 31);
      cfg_we    = (r >= 7);
      cfg_addr  = (r == 7) ? 12'h830 : (r == 8) ? 12'h82C : (r == 9) ? 12'h050 : 12'h830;
      cfg_wdata = $urandom;
      cycle();
    end
    msg_valid = 0; cfg_we = 0;
    idle(12'h830);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule